// File: doc/BRIEF.md
# Mode-Switched ROM/RAM Bank Mapper

This block sits on the cartridge side of an 8-bit processor with a 16-bit address bus. It widens the processor's 32 KB program space and 8 KB external-RAM window onto a much larger ROM and a banked RAM. A write that lands in the ROM address space never reaches ROM. It is taken as an update to one of three small control registers: the low part of the ROM bank number, a 2-bit upper register and a one-bit mode flag.

Reads in the lower 16 KB always come from the first ROM bank. Reads in the upper 16 KB come from a switchable bank. The 8 KB RAM window is placed in one of four RAM banks. The mode flag decides where the 2-bit upper register goes. In one mode it extends the ROM bank number. In the other it picks the RAM bank. A low bank field of zero is always replaced by one, so the switchable window never shows bank 0 again.

The address decode and the read-data mux are combinational. Only the control registers hold state, and they update on the clock edge at which a write strobe is sampled.

Top module: `bank_mapper_top`

## Requirements
- R1: After reset the low bank field is 1, the upper register is 0 and the mode is 0, so a read of 0x4000 drives ROM address 0x04000.
- R2: A read at 0x0000–0x3FFF asserts the ROM select and drives the ROM address equal to the CPU address.
- R3: A read at 0x4000–0x7FFF asserts the ROM select and drives ROM address = bank × 0x4000 + (CPU address − 0x4000). The read data returned to the CPU is the ROM data.
- R4: A write to 0x2000–0x3FFF loads data bits 4:0 into the low bank field. Data bits 7:5 have no effect.
- R5: When data bits 4:0 of that write are zero, the low bank field becomes 1. Banks 0x00, 0x20, 0x40 and 0x60 therefore map as 0x01, 0x21, 0x41 and 0x61.
- R6: A write to 0x4000–0x5FFF loads data bits 1:0 into the 2-bit upper register.
- R7: A write to 0x6000–0x7FFF loads data bit 0 into the mode flag.
- R8: In mode 0 the ROM bank is {upper, low}, with the upper register as bank bits 6:5. RAM accesses use RAM bank 0.
- R9: In mode 1 the ROM bank is the low field alone, with bank bits 6:5 zero. RAM accesses at 0xA000–0xBFFF use RAM address = upper × 0x2000 + (CPU address − 0xA000).
- R10: A write to 0xA000–0xBFFF asserts the RAM select and the RAM write enable at the same banked address a read would use, and passes the CPU data through. A read there returns the RAM data.
- R11: An access at 0x8000–0x9FFF or 0xC000–0xFFFF asserts neither select and returns read data 0.
- R12: A write to 0x0000–0x1FFF changes none of the mapping state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, sampled at the clock edge |
| cpu_rdata | output | 8 | Read data to the CPU, 0 when nothing is selected |
| rom_addr | output | 21 | External ROM byte address |
| rom_cs | output | 1 | ROM select, asserted on reads only |
| rom_data | input | 8 | Data returned by the ROM |
| ram_addr | output | 15 | External RAM byte address |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | Data to be written to RAM |
| ram_rdata | input | 8 | Data returned by the RAM |

## Verification
The assertions assume that the processor never raises its read and write strobes in the same cycle. They also assume that the address and data are stable while a strobe is high, so each strobe has a single meaning at the edge where the registers sample.

The bench drives every access as a single strobe, set up on the falling edge and dropped one cycle later. Every register write is followed by separate read cycles, so the address and data never change while a strobe is active.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int CPU_AW    = 16;
  localparam int DATA_W    = 8;
  localparam int ROM_WIN_W = 14;
  localparam int RAM_WIN_W = 13;
  localparam int LOW_W     = 5;
  localparam int HIGH_W    = 2;

  typedef enum logic [1:0] {
    RG_NONE     = 2'd0,
    RG_ROM_FIX  = 2'd1,
    RG_ROM_BANK = 2'd2,
    RG_RAM      = 2'd3
  } region_t;

  typedef enum logic [2:0] {
    CT_NONE   = 3'd0,
    CT_UNUSED = 3'd1,
    CT_LOW    = 3'd2,
    CT_HIGH   = 3'd3,
    CT_MODE   = 3'd4
  } ctl_t;
endpackage

// File: rtl/bm_decode.sv
module bm_decode
  import bm_pkg::*;
#(
  parameter int AW = CPU_AW
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output region_t       region,
  output ctl_t          ctl_sel,
  output logic          ctl_wr,
  output logic          idle
);
  localparam int TOP3 = AW - 3;

  logic [2:0] top3;
  assign top3 = addr[AW-1:TOP3];

  always_comb begin
    unique case (top3)
      3'b000, 3'b001: region = RG_ROM_FIX;
      3'b010, 3'b011: region = RG_ROM_BANK;
      3'b101:         region = RG_RAM;
      default:        region = RG_NONE;
    endcase
  end

  always_comb begin
    unique case (top3)
      3'b000:  ctl_sel = CT_UNUSED;
      3'b001:  ctl_sel = CT_LOW;
      3'b010:  ctl_sel = CT_HIGH;
      3'b011:  ctl_sel = CT_MODE;
      default: ctl_sel = CT_NONE;
    endcase
  end

  assign ctl_wr = wr && (ctl_sel != CT_NONE);
  assign idle   = (region == RG_NONE) || !(rd || wr);
endmodule

// File: rtl/bm_regs.sv
module bm_regs
  import bm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LOW_W,
  parameter int HW = HIGH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  ctl_t          ctl_sel,
  input  logic [DW-1:0] wdata,
  output logic [LW-1:0] low_q,
  output logic [HW-1:0] high_q,
  output logic          mode_q
);
  function automatic logic [LW-1:0] fix_low(input logic [DW-1:0] d);
    logic [LW-1:0] v;
    v = d[LW-1:0];
    if (v == '0) v = LW'(1);
    return v;
  endfunction

  logic low_we, high_we, mode_we;
  assign low_we  = ctl_wr && (ctl_sel == CT_LOW);
  assign high_we = ctl_wr && (ctl_sel == CT_HIGH);
  assign mode_we = ctl_wr && (ctl_sel == CT_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= LW'(1);
      high_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (low_we)  low_q  <= fix_low(wdata);
      if (high_we) high_q <= wdata[HW-1:0];
      if (mode_we) mode_q <= wdata[0];
    end
  end

  AST_LOW_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) low_q != '0); // R5
  AST_LOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (low_we && wdata[LW-1:0] != '0) |=> (low_q == $past(wdata[LW-1:0]))); // R4
  AST_LOW_ZERO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    (low_we && wdata[LW-1:0] == '0) |=> (low_q == LW'(1))); // R5
  AST_HIGH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    high_we |=> (high_q == $past(wdata[HW-1:0]))); // R6
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_q == $past(wdata[0]))); // R7
  AST_UNUSED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_sel == CT_UNUSED) |=> ($stable(low_q) && $stable(high_q) && $stable(mode_q))); // R12
endmodule

// File: rtl/bm_map.sv
module bm_map
  import bm_pkg::*;
#(
  parameter int AW  = CPU_AW,
  parameter int RW  = ROM_WIN_W,
  parameter int MW  = RAM_WIN_W,
  parameter int LW  = LOW_W,
  parameter int HW  = HIGH_W,
  localparam int BW     = LW + HW,
  localparam int ROM_AW = RW + BW,
  localparam int RAM_AW = MW + HW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              rd,
  input  logic              wr,
  input  region_t           region,
  input  logic [LW-1:0]     low_q,
  input  logic [HW-1:0]     high_q,
  input  logic              mode_q,
  output logic [BW-1:0]     rom_bank,
  output logic [HW-1:0]     ram_bank,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we
);
  function automatic logic [BW-1:0] calc_rom_bank(
    input logic [LW-1:0] lo, input logic [HW-1:0] hi, input logic md);
    return md ? {{HW{1'b0}}, lo} : {hi, lo};
  endfunction

  function automatic logic [HW-1:0] calc_ram_bank(input logic [HW-1:0] hi, input logic md);
    return md ? hi : '0;
  endfunction

  assign rom_bank = calc_rom_bank(low_q, high_q, mode_q);
  assign ram_bank = calc_ram_bank(high_q, mode_q);

  always_comb begin
    rom_addr = '0;
    unique case (region)
      RG_ROM_FIX:  rom_addr = {{BW{1'b0}}, addr[RW-1:0]};
      RG_ROM_BANK: rom_addr = {rom_bank, addr[RW-1:0]};
      default:     rom_addr = '0;
    endcase
  end

  assign rom_cs   = rd && ((region == RG_ROM_FIX) || (region == RG_ROM_BANK));
  assign ram_cs   = (rd || wr) && (region == RG_RAM);
  assign ram_we   = wr && (region == RG_RAM);
  assign ram_addr = {ram_bank, addr[MW-1:0]};

  AST_MODE0_RAM_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cs && !mode_q) |-> (ram_addr[RAM_AW-1:MW] == '0)); // R8
  AST_MODE1_RAM_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cs && mode_q) |-> (ram_addr[RAM_AW-1:MW] == high_q)); // R9
  AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs && region == RG_ROM_FIX) |-> (rom_addr[ROM_AW-1:RW] == '0)); // R2
  AST_WINDOW_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_cs && region == RG_ROM_BANK) |-> (rom_addr[RW+LW-1:RW] != '0)); // R5
  AST_RAM_WE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_cs); // R10
endmodule

// File: rtl/bank_mapper_top.sv
module bank_mapper_top
  import bm_pkg::*;
#(
  parameter int AW = CPU_AW,
  parameter int DW = DATA_W,
  parameter int RW = ROM_WIN_W,
  parameter int MW = RAM_WIN_W,
  parameter int LW = LOW_W,
  parameter int HW = HIGH_W,
  localparam int ROM_AW = RW + LW + HW,
  localparam int RAM_AW = MW + HW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DW-1:0]     cpu_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  input  logic [DW-1:0]     rom_data,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata
);
  region_t          region;
  ctl_t             ctl_sel;
  logic             ctl_wr;
  logic             idle;
  logic [LW-1:0]    low_q;
  logic [HW-1:0]    high_q;
  logic             mode_q;
  logic [LW+HW-1:0] rom_bank;
  logic [HW-1:0]    ram_bank;

  bm_decode #(.AW(AW)) u_decode (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .region(region), .ctl_sel(ctl_sel), .ctl_wr(ctl_wr), .idle(idle)
  );

  bm_regs #(.DW(DW), .LW(LW), .HW(HW)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel),
    .wdata(cpu_wdata), .low_q(low_q), .high_q(high_q), .mode_q(mode_q)
  );

  bm_map #(.AW(AW), .RW(RW), .MW(MW), .LW(LW), .HW(HW)) u_map (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
    .region(region), .low_q(low_q), .high_q(high_q), .mode_q(mode_q),
    .rom_bank(rom_bank), .ram_bank(ram_bank),
    .rom_addr(rom_addr), .rom_cs(rom_cs),
    .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we)
  );

  assign ram_wdata = cpu_wdata;

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      if (rom_cs)      cpu_rdata = rom_data;
      else if (ram_cs) cpu_rdata = ram_rdata;
    end
  end

  AST_SELECT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && ram_cs)); // R11
  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!rom_cs && !ram_cs && cpu_rdata == '0)); // R11
  AST_ROM_WRITE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> !rom_cs); // R4
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (low_q == LW'(1) && high_q == '0 && !mode_q)); // R1
endmodule

// File: tb/bank_mapper_top_tb.sv
module bank_mapper_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [20:0] rom_addr;
  logic        rom_cs;
  logic [7:0]  rom_data;
  logic [14:0] ram_addr;
  logic        ram_cs;
  logic        ram_we;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  bank_mapper_top u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .rom_addr(rom_addr), .rom_cs(rom_cs), .rom_data(rom_data),
    .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] rom_val(input logic [20:0] a);
    return a[7:0] ^ {1'b0, a[20:14]} ^ 8'h5A;
  endfunction
  assign rom_data = rom_val(rom_addr);

  logic [7:0] ram_mem [64];
  logic [5:0] ram_idx;
  assign ram_idx   = {ram_addr[14:13], ram_addr[3:0]};
  assign ram_rdata = ram_mem[ram_idx];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) ram_mem[i] <= 8'h00;
    end else if (ram_cs && ram_we) begin
      ram_mem[ram_idx] <= ram_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_cyc(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd_start(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
  endtask

  task automatic rd_end();
    cpu_rd = 1'b0;
  endtask

  task automatic rom_win_check(input string req, input logic [15:0] off, input logic [6:0] bank);
    logic [20:0] ea;
    ea = {bank, off[13:0]};
    rd_start(16'h4000 | off);
    chk(req, {11'd0, rom_cs, 20'd0}, {11'd0, 1'b1, 20'd0});
    chk(req, {11'd0, rom_addr}, {11'd0, ea});
    chk(req, {24'd0, cpu_rdata}, {24'd0, rom_val(ea)});
    rd_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state maps window to bank 1
    rom_win_check("R1", 16'h0000, 7'd1);
    rd_start(16'hA004);
    chk("R1", {17'd0, ram_addr}, 32'h0004);
    rd_end();

    // R2: fixed window sweep
    for (int a = 0; a < 16'h4000; a += 16'h0333) begin
      rd_start(a[15:0]);
      chk("R2", {31'd0, rom_cs}, 32'd1);
      chk("R2", {11'd0, rom_addr}, a);
      chk("R2", {24'd0, cpu_rdata}, {24'd0, rom_val(a[20:0])});
      rd_end();
    end

    // R3 R4 R5 R8: mode 0, every low and high value; upper data bits set
    for (int hi = 0; hi < 4; hi++) begin
      wr_cyc(16'h4000 | 16'(hi * 16'h0100), {6'b111111, hi[1:0]});
      for (int lo = 0; lo < 32; lo++) begin
        logic [4:0] el;
        el = (lo == 0) ? 5'd1 : lo[4:0];
        wr_cyc(16'h2000 | 16'(lo * 16'h00F0), {3'b111, lo[4:0]});
        rom_win_check(lo == 0 ? "R5" : "R3", 16'(lo * 16'h0209 + hi), {hi[1:0], el});
      end
      // R8: RAM stays in bank 0 in mode 0
      rd_start(16'hA00F);
      chk("R8", {17'd0, ram_addr}, 32'h000F);
      rd_end();
    end

    // R7 R9: mode 1, ROM bank drops upper bits, RAM bank follows upper register
    wr_cyc(16'h6000, 8'hFF);
    wr_cyc(16'h2000, 8'h13);
    for (int hi = 0; hi < 4; hi++) begin
      wr_cyc(16'h5FFF, 8'(hi));
      rom_win_check("R9", 16'h1234, 7'h13);
      // R10: write then read at the banked address
      @(negedge clk);
      cpu_addr = 16'hA000 | 16'(hi + 16'h0100); cpu_wdata = 8'hC0 | 8'(hi); cpu_wr = 1'b1;
      #1;
      chk("R10", {30'd0, ram_cs, ram_we}, 32'd3);
      chk("R10", {17'd0, ram_addr}, {17'd0, hi[1:0], 13'(hi + 16'h0100)});
      chk("R10", {24'd0, ram_wdata}, {24'd0, 8'hC0 | 8'(hi)});
      @(negedge clk);
      cpu_wr = 1'b0;
      rd_start(16'hA000 | 16'(hi + 16'h0100));
      chk("R9", {17'd0, ram_addr}, {17'd0, hi[1:0], 13'(hi + 16'h0100)});
      chk("R10", {24'd0, cpu_rdata}, {24'd0, 8'hC0 | 8'(hi)});
      rd_end();
    end
    // R9: banks hold distinct data (bank 2 vs bank 0 at same offset)
    wr_cyc(16'h4000, 8'h00);
    rd_start(16'hA102);
    chk("R9", {24'd0, cpu_rdata}, 32'h00);
    rd_end();

    // R7: back to mode 0 with bit 0 clear, other bits set
    wr_cyc(16'h4000, 8'h02);
    wr_cyc(16'h7ABC, 8'hFE);
    rom_win_check("R7", 16'h0010, 7'h53);
    rd_start(16'hA102);
    chk("R7", {17'd0, ram_addr}, 32'h0102);
    rd_end();

    // R6: upper register only takes bits 1:0
    wr_cyc(16'h4ABC, 8'hFD);
    rom_win_check("R6", 16'h0020, 7'h33);

    // R12: writes to the lowest quarter change nothing
    wr_cyc(16'h0000, 8'h0A);
    wr_cyc(16'h1FFF, 8'hFF);
    rom_win_check("R12", 16'h0030, 7'h33);
    rd_start(16'hA001);
    chk("R12", {17'd0, ram_addr}, 32'h0001);
    rd_end();

    // R11: unmapped windows
    for (int k = 0; k < 6; k++) begin
      logic [15:0] a;
      a = (k < 2) ? 16'(16'h8000 + k * 16'h1FFF) : 16'(16'hC000 + (k - 2) * 16'h1555);
      rd_start(a);
      chk("R11", {30'd0, rom_cs, ram_cs}, 32'd0);
      chk("R11", {24'd0, cpu_rdata}, 32'd0);
      rd_end();
      @(negedge clk);
      cpu_addr = a; cpu_wdata = 8'h77; cpu_wr = 1'b1;
      #1;
      chk("R11", {29'd0, rom_cs, ram_cs, ram_we}, 32'd0);
      @(negedge clk);
      cpu_wr = 1'b0;
    end
    rom_win_check("R11", 16'h0040, 7'h33);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule